// File: doc/BRIEF.md
# Clock Source Selector with Prescaler and Calibration Sequencer

This block picks which clock feeds a bank of downstream channel dividers: either an external clock input or the clock from an on-chip oscillator. The chosen source can go through a small integer prescaler, with ratios from two to six. The external clock may also skip the prescaler. The oscillator always goes through the prescaler, because its raw frequency is above what the channel dividers accept.

Both source clocks come in as level waveforms. The block oversamples them on its own control clock. A synchronizer chain removes metastability, and a rising-edge detector turns each source period into a single-cycle event that advances the prescaler. A configuration write that carries a forbidden code is rejected whole: the last accepted setting stays in force and an error flag rises.

Oscillator calibration starts only on an explicit request pulse. While it runs, the block drives a sync output that freezes the downstream distribution, and it holds its own clock output low. When the oscillator model reports completion, the block lets go of sync one cycle later.

Top module: `clk_src_presc`

## Requirements
- R1: Select code 2'b00 routes the external clock through the prescaler, so `div_clk_o` has a period of exactly `ratio` external-clock periods.
- R2: Select code 2'b01 bypasses the prescaler. `div_clk_o` follows the external clock with the same high and low times, and the ratio field has no effect.
- R3: Select code 2'b10 routes the oscillator clock through the prescaler, so `div_clk_o` has a period of exactly `ratio` oscillator periods.
- R4: A write with select code 2'b11 is rejected whole, and the previous selection and ratio stay in force. `cfg_err_o` is high in the cycle after the write and stays high until the next accepted write, which clears it.
- R5: `cfg_ratio_i` holds the divisor value itself. A write whose ratio lies outside 2 to 6 is rejected in the same way as R4.
- R6: When the prescaler is used, the output is high for floor(ratio/2) source periods and low for ceil(ratio/2) source periods. Odd ratios are therefore high one source period shorter than low.
- R7: Calibration begins only on a `cal_start_i` pulse seen while idle. `cal_busy_o` and `dist_sync_o` both rise in the cycle after the pulse. Configuration writes never start a calibration.
- R8: While `dist_sync_o` is high, `div_clk_o` is held low.
- R9: When `cal_done_i` is seen while busy, `cal_busy_o` falls in the next cycle while `dist_sync_o` stays high for that one cycle. `dist_sync_o` falls in the cycle after that.
- R10: A `cal_start_i` pulse during a running calibration is ignored. Busy holds until done, and no second calibration follows the release.
- R11: While reset is asserted, `div_clk_o`, `dist_sync_o`, `cal_busy_o` and `cfg_err_o` are all low. The configuration comes out of reset as select 2'b00 with ratio 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Control and oversampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External source clock level |
| osc_clk_i | input | 1 | Internal oscillator clock level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Source select code: 00, 01, 10 valid; 11 forbidden |
| cfg_ratio_i | input | RATIO_W | Prescaler divisor, 2 to 6 |
| cal_start_i | input | 1 | Calibration request pulse |
| cal_done_i | input | 1 | Calibration finished, from the oscillator model |
| div_clk_o | output | 1 | Selected and optionally prescaled clock |
| dist_sync_o | output | 1 | Holds downstream distribution in sync |
| cal_busy_o | output | 1 | Calibration running |
| cfg_err_o | output | 1 | Last configuration write was rejected |

## Verification
The calibration and configuration outputs are registered, so each one is sampled at the falling edge that follows the rising edge after its stimulus. For example, busy and sync are checked one cycle after the start pulse, sync alone one cycle after done, and the error flag one cycle after the write. The clock output moves only after a sampler chain and an edge detector, and that delay would be fragile to count. Instead the bench lets the output settle after each write and then measures whole high and low run lengths. These lengths are independent of latency and are compared with the source half-period times the duty split that the ratio sets. The cycle-exact checks on the sync release are repeated by the bound assertions on every cycle.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   typedef enum logic [1:0] {
      SRC_EXT_DIV = 2'b00,
      SRC_EXT_BYP = 2'b01,
      SRC_OSC_DIV = 2'b10,
      SRC_RSVD    = 2'b11
   } src_sel_e;

   typedef enum logic [1:0] {
      CAL_IDLE = 2'd0,
      CAL_RUN  = 2'd1,
      CAL_REL  = 2'd2
   } cal_st_e;

endpackage

// File: rtl/clksel_cfg.sv
module clksel_cfg
   import clksel_pkg::*;
#(
   parameter int RATIO_W   = 3,
   parameter int RATIO_MIN = 2,
   parameter int RATIO_MAX = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [1:0]         sel_in,
   input  logic [RATIO_W-1:0] ratio_in,
   output src_sel_e           sel_q,
   output logic [RATIO_W-1:0] ratio_q,
   output logic               err_q,
   output logic               chg_q
);

   localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(RATIO_MIN);
   localparam logic [RATIO_W-1:0] MAX_V = RATIO_W'(RATIO_MAX);

   if (RATIO_MIN < 2) begin : g_bad_min
      $error("clksel_cfg: RATIO_MIN must be at least 2");
   end
   if (RATIO_MAX >= (1 << RATIO_W)) begin : g_bad_max
      $error("clksel_cfg: RATIO_MAX does not fit in RATIO_W bits");
   end

   logic ok;
   assign ok = (src_sel_e'(sel_in) != SRC_RSVD) && (ratio_in >= MIN_V) && (ratio_in <= MAX_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= SRC_EXT_DIV;
         ratio_q <= MIN_V;
         err_q   <= 1'b0;
         chg_q   <= 1'b0;
      end else begin
         chg_q <= 1'b0;
         if (we) begin
            if (ok) begin
               sel_q   <= src_sel_e'(sel_in);
               ratio_q <= ratio_in;
               err_q   <= 1'b0;
               chg_q   <= 1'b1;
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/clksel_sampler.sv
module clksel_sampler #(
   parameter int N      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] lvl,
   output logic [N-1:0] rise
);

   if (STAGES < 1) begin : g_bad_stages
      $error("clksel_sampler: STAGES must be at least 1");
   end

   logic [N-1:0] stg [STAGES];
   logic [N-1:0] prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= stg[STAGES-1];
   end

   assign lvl  = stg[STAGES-1];
   assign rise = stg[STAGES-1] & ~prev;

endmodule

// File: rtl/clksel_presc.sv
module clksel_presc #(
   parameter int RATIO_W   = 3,
   parameter int RATIO_MIN = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               bypass,
   input  logic               src_lvl,
   input  logic               src_rise,
   input  logic [RATIO_W-1:0] ratio,
   output logic               div_q
);

   logic [RATIO_W-1:0] cnt, cnt_nx, half;

   // high slots are 0 .. half-1, so odd ratios get the shorter high phase
   assign half   = ratio >> 1;
   assign cnt_nx = (cnt == ratio - 1'b1) ? '0 : cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= RATIO_W'(RATIO_MIN - 1);
         div_q <= 1'b0;
      end else if (restart) begin
         cnt   <= ratio - 1'b1;
         div_q <= 1'b0;
      end else if (bypass) begin
         div_q <= src_lvl;
      end else if (src_rise) begin
         cnt   <= cnt_nx;
         div_q <= (cnt_nx < half);
      end
   end

endmodule

// File: rtl/clksel_calseq.sv
module clksel_calseq
   import clksel_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy,
   output logic sync
);

   cal_st_e st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         CAL_IDLE: if (start) st_nx = CAL_RUN;
         CAL_RUN:  if (done)  st_nx = CAL_REL;
         CAL_REL:  st_nx = CAL_IDLE;
         default:  st_nx = CAL_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= CAL_IDLE;
      else        st <= st_nx;
   end

   assign busy = (st == CAL_RUN);
   assign sync = (st != CAL_IDLE);

endmodule

// File: rtl/clk_src_presc.sv
module clk_src_presc
   import clksel_pkg::*;
#(
   parameter int RATIO_W     = 3,
   parameter int RATIO_MIN   = 2,
   parameter int RATIO_MAX   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               ext_clk_i,
   input  logic               osc_clk_i,
   input  logic               cfg_we_i,
   input  logic [1:0]         cfg_sel_i,
   input  logic [RATIO_W-1:0] cfg_ratio_i,
   input  logic               cal_start_i,
   input  logic               cal_done_i,
   output logic               div_clk_o,
   output logic               dist_sync_o,
   output logic               cal_busy_o,
   output logic               cfg_err_o
);

   localparam int IDX_EXT = 0;
   localparam int IDX_OSC = 1;

   src_sel_e           sel_q;
   logic [RATIO_W-1:0] ratio_q;
   logic               chg;
   logic [1:0]         lvl, rise;
   logic               sel_osc, sel_lvl, sel_rise, div_q;

   clksel_cfg #(.RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)) u_cfg (
      .clk(clk_i), .rst_n(rst_ni), .we(cfg_we_i), .sel_in(cfg_sel_i), .ratio_in(cfg_ratio_i),
      .sel_q(sel_q), .ratio_q(ratio_q), .err_q(cfg_err_o), .chg_q(chg)
   );

   clksel_sampler #(.N(2), .STAGES(SYNC_STAGES)) u_smp (
      .clk(clk_i), .rst_n(rst_ni), .d({osc_clk_i, ext_clk_i}), .lvl(lvl), .rise(rise)
   );

   assign sel_osc  = (sel_q == SRC_OSC_DIV);
   assign sel_lvl  = sel_osc ? lvl[IDX_OSC]  : lvl[IDX_EXT];
   assign sel_rise = sel_osc ? rise[IDX_OSC] : rise[IDX_EXT];

   clksel_calseq u_cal (
      .clk(clk_i), .rst_n(rst_ni), .start(cal_start_i), .done(cal_done_i),
      .busy(cal_busy_o), .sync(dist_sync_o)
   );

   clksel_presc #(.RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN)) u_presc (
      .clk(clk_i), .rst_n(rst_ni), .restart(chg | dist_sync_o),
      .bypass(sel_q == SRC_EXT_BYP), .src_lvl(sel_lvl), .src_rise(sel_rise),
      .ratio(ratio_q), .div_q(div_q)
   );

   assign div_clk_o = div_q & ~dist_sync_o;

endmodule

// File: rtl/clk_src_presc_chk.sv
module clk_src_presc_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       cfg_we_i,
   input logic [1:0] cfg_sel_i,
   input logic       cal_start_i,
   input logic       cal_done_i,
   input logic       div_clk_o,
   input logic       dist_sync_o,
   input logic       cal_busy_o,
   input logic       cfg_err_o
);

   a_r4_bad_sel_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_sel_i == 2'b11) |=> cfg_err_o);

   a_r7_busy_means_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cal_busy_o |-> dist_sync_o);

   a_r7_start_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cal_busy_o) |-> $past(cal_start_i));

   a_r8_output_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dist_sync_o |-> !div_clk_o);

   a_r9_done_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cal_busy_o && cal_done_i) |=> (dist_sync_o && !cal_busy_o));

   a_r9_sync_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dist_sync_o && !cal_busy_o) |=> !dist_sync_o);

   a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cal_busy_o && !cal_done_i) |=> cal_busy_o);

endmodule

bind clk_src_presc clk_src_presc_chk u_chk (.*);

// File: tb/clk_src_presc_test.sv
module clk_src_presc_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int EXT_H = 2;
   localparam int OSC_H = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_clk = 1'b0, osc_clk = 1'b0;
   logic       we = 1'b0;
   logic [1:0] sel = 2'b00;
   logic [2:0] ratio = 3'd2;
   logic       cal_start = 1'b0, cal_done = 1'b0;
   logic       div_clk, dist_sync, cal_busy, cfg_err;

   int checks = 0;
   int errs = 0;

   always #4 clk = ~clk;

   clk_src_presc uut (
      .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .osc_clk_i(osc_clk),
      .cfg_we_i(we), .cfg_sel_i(sel), .cfg_ratio_i(ratio),
      .cal_start_i(cal_start), .cal_done_i(cal_done),
      .div_clk_o(div_clk), .dist_sync_o(dist_sync), .cal_busy_o(cal_busy), .cfg_err_o(cfg_err)
   );

   int ext_cnt = 0, osc_cnt = 0;
   always @(negedge clk) begin
      ext_cnt <= (ext_cnt == EXT_H - 1) ? 0 : ext_cnt + 1;
      osc_cnt <= (osc_cnt == OSC_H - 1) ? 0 : osc_cnt + 1;
      if (ext_cnt == EXT_H - 1) ext_clk <= ~ext_clk;
      if (osc_cnt == OSC_H - 1) osc_clk <= ~osc_clk;
   end

   function automatic int exp_hi(input int s, input int r);
      if (s == 1) return EXT_H;
      return (r / 2) * 2 * ((s == 2) ? OSC_H : EXT_H);
   endfunction

   function automatic int exp_lo(input int s, input int r);
      if (s == 1) return EXT_H;
      return (r - r / 2) * 2 * ((s == 2) ? OSC_H : EXT_H);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [2:0] r);
      @(negedge clk);
      we = 1'b1; sel = s; ratio = r;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic measure(output int hi, output int lo);
      int guard = 0;
      repeat (40) @(negedge clk);
      while (div_clk !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
      while (div_clk !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
      hi = 0;
      while (div_clk === 1'b1 && guard < 400) begin hi++; @(negedge clk); guard++; end
      lo = 0;
      while (div_clk === 1'b0 && guard < 400) begin lo++; @(negedge clk); guard++; end
   endtask

   task automatic check_shape(input string req, input int s, input int r);
      int hi, lo;
      measure(hi, lo);
      chk({req, " high run"}, hi, exp_hi(s, r));
      chk({req, " low run"},  lo, exp_lo(s, r));
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R11: reset values
      chk("R11 div_clk in reset", int'(div_clk), 0);
      chk("R11 sync in reset", int'(dist_sync), 0);
      chk("R11 busy in reset", int'(cal_busy), 0);
      chk("R11 err in reset", int'(cfg_err), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: out of reset as select 00 ratio 2
      check_shape("R11 R1 default ext/2", 0, 2);

      // R1 / R6 directed odd and even ratios
      cfg_write(2'b00, 3'd5);
      check_shape("R1 R6 ext/5", 0, 5);
      cfg_write(2'b00, 3'd6);
      check_shape("R1 ext/6", 0, 6);
      // R2 bypass, ratio irrelevant
      cfg_write(2'b01, 3'd3);
      check_shape("R2 bypass ratio3", 1, 3);
      cfg_write(2'b01, 3'd6);
      check_shape("R2 bypass ratio6", 1, 6);
      // R3 oscillator
      cfg_write(2'b10, 3'd3);
      check_shape("R3 R6 osc/3", 2, 3);
      chk("R7 writes never start calibration", int'(cal_busy), 0);

      // R4 forbidden select keeps osc/3
      cfg_write(2'b11, 3'd5);
      chk("R4 err after select 11", int'(cfg_err), 1);
      check_shape("R4 previous osc/3 kept", 2, 3);
      cfg_write(2'b00, 3'd4);
      chk("R4 err cleared by valid write", int'(cfg_err), 0);
      // R5 out-of-range ratio
      cfg_write(2'b10, 3'd7);
      chk("R5 err after ratio 7", int'(cfg_err), 1);
      check_shape("R5 previous ext/4 kept", 0, 4);
      cfg_write(2'b00, 3'd1);
      chk("R5 err after ratio 1", int'(cfg_err), 1);
      check_shape("R5 ext/4 still kept", 0, 4);

      // random configurations
      for (int i = 0; i < 8; i++) begin
         int s = int'($urandom % 3);
         int r = 2 + int'($urandom % 5);
         cfg_write(s[1:0], r[2:0]);
         chk("R5 random valid write no err", int'(cfg_err), 0);
         check_shape((s == 1) ? "R2 random" : (s == 2) ? "R3 R6 random" : "R1 R6 random", s, r);
      end

      // calibration
      cfg_write(2'b00, 3'd2);
      repeat (20) @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      chk("R7 busy after start", int'(cal_busy), 1);
      chk("R7 sync after start", int'(dist_sync), 1);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk("R8 output held during sync", int'(div_clk), 0);
         if (i == 4) cal_start = 1'b1;
         if (i == 5) cal_start = 1'b0;
      end
      chk("R10 still busy after extra start", int'(cal_busy), 1);
      cal_done = 1'b1;
      @(negedge clk);
      cal_done = 1'b0;
      chk("R9 busy low after done", int'(cal_busy), 0);
      chk("R9 sync still high one cycle", int'(dist_sync), 1);
      @(negedge clk);
      chk("R9 sync low", int'(dist_sync), 0);
      begin
         int seen = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dist_sync || cal_busy) seen++;
         end
         chk("R10 no second calibration", seen, 0);
      end
      check_shape("R8 output resumes ext/2", 0, 2);
      // R7: done without a start does nothing
      cal_done = 1'b1;
      @(negedge clk);
      cal_done = 1'b0;
      @(negedge clk);
      chk("R7 done alone no sync", int'(dist_sync), 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule